// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk

This block turns a 32-bit virtual address into a physical address for a single requester. The address is split into a 20-bit page number and a 12-bit offset within a 4 KB page. The page number, together with an address-space identifier, is looked up in a small fully associative buffer of recent translations. On a hit the physical address, built from the cached frame number and the untouched offset, comes back in the cycle after the request is accepted.

On a miss the block stops taking requests, issues one read on its memory port to the page table entry at the base register plus four times the page number, and waits for the data. A valid entry is installed in the buffer, replacing slots in round-robin order, and the translation is returned. An entry with its valid bit clear returns a page fault and is not installed. Every response also checks the requested access type against the entry's read, write and execute permissions. The base register can only be written while the kernel-mode input is high, and a flush input invalidates every cached translation.

Top module: `addr_xlate_unit`

## Requirements
- R1: The physical address of a successful response is the 20-bit frame number in bits 31:12 and the request's virtual address bits 11:0 in bits 11:0; a faulting response returns address 0.
- R2: A lookup accepted while a matching entry is cached produces, in the next cycle, rsp_valid=1 and rsp_hit=1 with no memory read.
- R3: An entry matches only when it is valid and both its page number and its address-space id equal the request's; the same page under another id misses.
- R4: On a miss, exactly one memory read is issued at base + (virtual page number × 4); req_ready is 0 from the cycle after acceptance until the response cycle, when it returns to 1.
- R5: The page table entry layout is bit 31 valid, bit 30 dirty, bit 29 read, bit 28 write, bit 27 execute, bits 19:0 frame number; a valid entry returned by memory is installed and answered with rsp_valid=1, rsp_hit=0 in the cycle after mem_rd_valid.
- R6: An entry returned with bit 31 clear gives rsp_pfault=1, rsp_hit=0, address 0, and is not installed, so the next lookup of that page walks again.
- R7: Access type 0 is read, 1 write, 2 execute and 3 is never permitted; when the entry's matching permission bit is clear rsp_perm_fault=1 with address 0, on both hit and walk responses, and a walk that faults on permission still installs the valid entry.
- R8: The buffer holds 8 entries filled in round-robin order from slot 0 after reset; the ninth installation after a flush evicts the first one installed.
- R9: A cycle with flush high invalidates every cached entry; the following lookups miss.
- R10: The base register takes ptbr_wdata only in a cycle where ptbr_we and kernel_mode are both high; a write with kernel_mode low is ignored.
- R11: After reset req_ready=1, rsp_valid=0, mem_rd_en=0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Address-space identifier of the request |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response was served from the buffer |
| rsp_paddr | output | 32 | Translated physical address, 0 on a fault |
| rsp_pfault | output | 1 | Page table entry was not valid |
| rsp_perm_fault | output | 1 | Access type not permitted by the entry |
| kernel_mode | input | 1 | Privilege qualifier for base register writes |
| ptbr_we | input | 1 | Base register write strobe |
| ptbr_wdata | input | 32 | Base register write value |
| flush | input | 1 | Invalidate all cached translations |
| mem_rd_en | output | 1 | One-cycle page table read request |
| mem_rd_addr | output | 32 | Byte address of the page table entry |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Page table entry read from memory |

## Verification
Every cycle the assertions check that a hit answers in the next cycle, that at most one cached entry matches, that a flush leaves no valid entry, that each table read is a single-cycle pulse issued while lookups are blocked, that an invalid entry yields a page fault with address 0, and that the base register holds its value unless a privileged write occurs. Only the bench scenarios show that the read address follows the base register and page number, that the round-robin order evicts the oldest entry, that invalid entries are never cached, that a different address-space id misses, and that permission faults follow the entry bits for each access type under random traffic.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W     = 32;
    localparam int PG_OFF_W = 12;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PPN_W    = 20;
    localparam int ASID_W   = 8;

    localparam int PTE_V_BIT = 31;
    localparam int PTE_D_BIT = 30;
    localparam int PTE_R_BIT = 29;
    localparam int PTE_W_BIT = 28;
    localparam int PTE_X_BIT = 27;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic              rd;
        logic              wr;
        logic              ex;
        logic              dirty;
    } xl_entry_t;

    function automatic logic acc_ok(input xl_entry_t e, input acc_e a);
        case (a)
            ACC_RD:  return e.rd;
            ACC_WR:  return e.wr;
            ACC_EX:  return e.ex;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/xlate_cam.sv
module xlate_cam
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output xl_entry_t         lk_entry,
    input  logic              fill_en,
    input  xl_entry_t         fill_entry
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        xl_entry_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]        ptr;
    } cam_st_t;

    cam_st_t st_d, st_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] vld_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign vld_vec[g] = st_q.ent[g].vld;
        assign match[g]   = st_q.ent[g].vld
                          && (st_q.ent[g].vpn  == lk_vpn)
                          && (st_q.ent[g].asid == lk_asid);
    end

    always_comb begin
        lk_hit   = |match;
        lk_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_entry = xl_entry_t'(lk_entry | st_q.ent[i]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.ent[st_q.ptr] = fill_entry;
            st_d.ptr = (st_q.ptr == PTR_LAST) ? '0 : st_q.ptr + 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: tags are unique, so a lookup never matches two slots
    assert_one_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // R9: a flush leaves nothing valid
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));
    // R11: empty out of reset
    assert_reset_empty_R11: assert property (@(posedge clk)
        !rst_n |=> (vld_vec == '0));
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [VA_W-1:0]  base,
    output logic             busy,
    output logic             mem_rd_en,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [31:0]      mem_rd_data,
    output logic             done,
    output logic [31:0]      pte
);
    typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT} wk_state_e;

    typedef struct packed {
        wk_state_e       state;
        logic [VA_W-1:0] addr;
    } wk_st_t;

    wk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            WK_IDLE: if (start) begin
                st_d.state = WK_REQ;
                st_d.addr  = base + VA_W'({start_vpn, 2'b00});
            end
            WK_REQ:  st_d.state = WK_WAIT;
            WK_WAIT: if (mem_rd_valid) st_d.state = WK_IDLE;
            default: st_d.state = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: WK_IDLE, addr: '0};
        else        st_q <= st_d;
    end

    assign busy        = (st_q.state != WK_IDLE);
    assign mem_rd_en   = (st_q.state == WK_REQ);
    assign mem_rd_addr = st_q.addr;
    assign done        = (st_q.state == WK_WAIT) && mem_rd_valid;
    assign pte         = mem_rd_data;

    // R4: one read pulse per walk
    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    // R4: the top never starts a walk while one is running
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_acc,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_pfault,
    output logic              rsp_perm_fault,
    input  logic              kernel_mode,
    input  logic              ptbr_we,
    input  logic [VA_W-1:0]   ptbr_wdata,
    input  logic              flush,
    output logic              mem_rd_en,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data
);
    typedef struct packed {
        logic [VA_W-1:0]     ptbr;
        logic [VPN_W-1:0]    p_vpn;
        logic [ASID_W-1:0]   p_asid;
        acc_e                p_acc;
        logic [PG_OFF_W-1:0] p_off;
        logic                rv;
        logic                rh;
        logic                rpf;
        logic                rperm;
        logic [VA_W-1:0]     rpa;
    } top_st_t;

    top_st_t st_d, st_q;

    logic        cam_hit;
    xl_entry_t   cam_ent;
    xl_entry_t   fill_entry;
    logic        fill_en;
    logic        wk_busy, wk_done, accept, wk_start;
    logic [31:0] wk_pte;
    acc_e        acc_in;

    assign acc_in    = acc_e'(req_acc);
    assign req_ready = !wk_busy;
    assign accept    = req_valid && !wk_busy;
    assign wk_start  = accept && !cam_hit;

    always_comb begin
        fill_entry.vld   = wk_pte[PTE_V_BIT];
        fill_entry.dirty = wk_pte[PTE_D_BIT];
        fill_entry.rd    = wk_pte[PTE_R_BIT];
        fill_entry.wr    = wk_pte[PTE_W_BIT];
        fill_entry.ex    = wk_pte[PTE_X_BIT];
        fill_entry.ppn   = wk_pte[PPN_W-1:0];
        fill_entry.vpn   = st_q.p_vpn;
        fill_entry.asid  = st_q.p_asid;
    end
    assign fill_en = wk_done && wk_pte[PTE_V_BIT];

    xlate_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_vpn     (req_vaddr[VA_W-1:PG_OFF_W]),
        .lk_asid    (req_asid),
        .lk_hit     (cam_hit),
        .lk_entry   (cam_ent),
        .fill_en    (fill_en),
        .fill_entry (fill_entry)
    );

    xlate_walker u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (wk_start),
        .start_vpn    (req_vaddr[VA_W-1:PG_OFF_W]),
        .base         (st_q.ptbr),
        .busy         (wk_busy),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .done         (wk_done),
        .pte          (wk_pte)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rv    = 1'b0;
        st_d.rh    = 1'b0;
        st_d.rpf   = 1'b0;
        st_d.rperm = 1'b0;
        st_d.rpa   = '0;
        if (ptbr_we && kernel_mode) st_d.ptbr = ptbr_wdata;
        if (accept) begin
            st_d.p_vpn  = req_vaddr[VA_W-1:PG_OFF_W];
            st_d.p_asid = req_asid;
            st_d.p_acc  = acc_in;
            st_d.p_off  = req_vaddr[PG_OFF_W-1:0];
            if (cam_hit) begin
                st_d.rv = 1'b1;
                st_d.rh = 1'b1;
                if (acc_ok(cam_ent, acc_in))
                    st_d.rpa = {cam_ent.ppn, req_vaddr[PG_OFF_W-1:0]};
                else
                    st_d.rperm = 1'b1;
            end
        end
        if (wk_done) begin
            st_d.rv = 1'b1;
            if (!wk_pte[PTE_V_BIT])
                st_d.rpf = 1'b1;
            else if (acc_ok(fill_entry, st_q.p_acc))
                st_d.rpa = {fill_entry.ppn, st_q.p_off};
            else
                st_d.rperm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{p_acc: ACC_RD, default: '0};
        else        st_q <= st_d;
    end

    assign rsp_valid      = st_q.rv;
    assign rsp_hit        = st_q.rh;
    assign rsp_paddr      = st_q.rpa;
    assign rsp_pfault     = st_q.rpf;
    assign rsp_perm_fault = st_q.rperm;

    // R2: a hit answers in the next cycle
    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cam_hit) |=> (rsp_valid && rsp_hit));
    // R4: lookups are blocked while the table read is out
    assert_ready_low_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);
    // R6: an invalid table entry faults with a zero address
    assert_invalid_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_done && !wk_pte[PTE_V_BIT]) |=> (rsp_pfault && !rsp_hit && rsp_paddr == '0));
    // R7: the two fault kinds never appear together
    assert_fault_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_pfault && rsp_perm_fault));
    // R10: the base register moves only on a privileged write
    assert_ptbr_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ptbr_we && kernel_mode) |=> $stable(st_q.ptbr));
endmodule

// File: tb/sim_addr_xlate_unit.sv
module sim_addr_xlate_unit;
    import xlate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_acc = '0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_pfault, rsp_perm_fault;
    logic [31:0] rsp_paddr;
    logic        kernel_mode = 1'b0;
    logic        ptbr_we = 1'b0;
    logic [31:0] ptbr_wdata = '0;
    logic        flush = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    addr_xlate_unit #(.ENTRIES(NSLOT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_asid(req_asid), .req_acc(req_acc), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_pfault(rsp_pfault), .rsp_perm_fault(rsp_perm_fault),
        .kernel_mode(kernel_mode), .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata),
        .flush(flush), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // reference buffer model
    logic [19:0] m_vpn  [NSLOT];
    logic [7:0]  m_asid [NSLOT];
    bit          m_vld  [NSLOT];
    int          m_ptr = 0;
    logic [31:0] m_ptbr = '0;

    // table content: a function of the entry address (base has bits 21:0 zero)
    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        logic [31:0] p = '0;
        p[31]   = (vpn[2:0] != 3'd5);
        p[30]   = vpn[3];
        p[29]   = ~vpn[4];
        p[28]   = vpn[5];
        p[27]   = vpn[6];
        p[19:0] = vpn ^ 20'h5A5A3;
        return p;
    endfunction

    function automatic bit perm_ok(input logic [31:0] p, input logic [1:0] a);
        case (a)
            2'd0: return p[29];
            2'd1: return p[28];
            2'd2: return p[27];
            default: return 1'b0;
        endcase
    endfunction

    // memory model, driven away from the active edge
    bit          mem_pend = 0;
    int          mem_cnt = 0;
    logic [31:0] mem_addr = '0;
    logic [31:0] last_rd_addr = '0;
    int          rd_count = 0;

    always @(negedge clk) begin
        if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
            mem_pend     = 0;
        end else if (mem_pend) begin
            if (mem_cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = pte_of(mem_addr[21:2]);
            end else mem_cnt--;
        end
        if (mem_rd_en) begin
            mem_pend     = 1;
            mem_cnt      = $urandom % 3;
            mem_addr     = mem_rd_addr;
            last_rd_addr = mem_rd_addr;
            rd_count++;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_ptbr(input logic [31:0] v, input bit kmode);
        @(negedge clk);
        ptbr_we = 1'b1; ptbr_wdata = v; kernel_mode = kmode;
        @(negedge clk);
        ptbr_we = 1'b0; kernel_mode = 1'b0;
        if (kmode) m_ptbr = v;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < NSLOT; i++) m_vld[i] = 0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] asid,
                          input logic [1:0] acc, input string tag);
        logic [19:0] vpn = va[31:12];
        bit          hit = 0;
        int          rd0;
        int          guard;
        logic [31:0] p;
        bit          pf, pm;
        for (int i = 0; i < NSLOT; i++)
            if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) hit = 1;
        p = pte_of(vpn);
        @(negedge clk);
        chk(tag, "req_ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_asid = asid; req_acc = acc;
        rd0 = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk(tag, "hit rsp_valid next cycle (R2)", {31'd0, rsp_valid}, 32'd1);
            chk(tag, "rsp_hit (R2/R3)", {31'd0, rsp_hit}, 32'd1);
            chk(tag, "no table read on hit (R2)", rd_count - rd0, 32'd0);
        end else begin
            chk(tag, "miss has no early rsp (R3)", {31'd0, rsp_valid}, 32'd0);
            chk(tag, "req_ready low in walk (R4)", {31'd0, req_ready}, 32'd0);
            guard = 0;
            while (!rsp_valid && guard < 40) begin
                @(negedge clk);
                if (!rsp_valid) chk(tag, "req_ready low until rsp (R4)", {31'd0, req_ready}, 32'd0);
                guard++;
            end
            chk(tag, "walk response arrives (R5)", {31'd0, rsp_valid}, 32'd1);
            chk(tag, "rsp_hit on walk (R5)", {31'd0, rsp_hit}, 32'd0);
            chk(tag, "one table read (R4)", rd_count - rd0, 32'd1);
            chk(tag, "table read address (R4)", last_rd_addr, m_ptbr + {10'd0, vpn, 2'b00});
            chk(tag, "req_ready back at rsp (R4)", {31'd0, req_ready}, 32'd1);
        end
        pf = !hit && !p[31];
        pm = !pf && !perm_ok(p, acc);
        chk(tag, "rsp_pfault (R6)", {31'd0, rsp_pfault}, {31'd0, pf});
        chk(tag, "rsp_perm_fault (R7)", {31'd0, rsp_perm_fault}, {31'd0, pm});
        chk(tag, "rsp_paddr (R1)", rsp_paddr, (pf || pm) ? 32'd0 : {p[19:0], va[11:0]});
        if (!hit && p[31]) begin
            m_vpn[m_ptr] = vpn; m_asid[m_ptr] = asid; m_vld[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % NSLOT;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NSLOT; i++) m_vld[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R11", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R11", "mem_rd_en after reset", {31'd0, mem_rd_en}, 32'd0);

        set_ptbr(32'h0040_0000, 1);
        lookup(32'h0000_1ABC, 8'd3, 2'd0, "R11");   // empty buffer: walk
        lookup(32'h0000_1ABC, 8'd3, 2'd0, "R2");    // now a hit
        lookup(32'h0000_1FF0, 8'd3, 2'd2, "R1");    // hit, new offset
        lookup(32'h0000_1ABC, 8'd4, 2'd0, "R3");    // other id misses
        lookup(32'h0000_5123, 8'd3, 2'd0, "R6");    // invalid entry
        lookup(32'h0000_5123, 8'd3, 2'd0, "R6");    // not cached: walks again
        lookup(32'h0000_1ABC, 8'd3, 2'd1, "R7");    // hit, write denied
        lookup(32'h0000_1ABC, 8'd3, 2'd3, "R7");    // reserved type
        lookup(32'h0006_0010, 8'd1, 2'd1, "R7");    // walk, write permitted
        lookup(32'h0001_0010, 8'd1, 2'd0, "R7");    // walk, read denied, installed
        lookup(32'h0001_0020, 8'd1, 2'd2, "R5");    // hit on that entry

        set_ptbr(32'h00C0_0000, 0);                 // ignored
        lookup(32'h0002_0000, 8'd3, 2'd0, "R10");
        set_ptbr(32'h00C0_0000, 1);
        lookup(32'h0002_1000, 8'd3, 2'd0, "R10");

        do_flush();
        lookup(32'h0000_1ABC, 8'd3, 2'd0, "R9");    // must miss after flush
        do_flush();
        for (int k = 0; k < 9; k++)
            lookup({12'd0, 20'h00100 + 20'(8 * k)} << 12 | 32'h0000_0044, 8'd2, 2'd0, "R8");
        lookup(32'h0010_0044, 8'd2, 2'd0, "R8");    // oldest evicted: walk
        lookup(32'h0014_0044, 8'd2, 2'd0, "R8");    // newest still cached

        for (int n = 0; n < 500; n++) begin
            logic [31:0] va;
            va = {12'd0, 20'($urandom % 24)} << 12 | (32'($urandom) & 32'hFFF);
            if ($urandom % 60 == 0) do_flush();
            lookup(va, 8'($urandom % 2), 2'($urandom % 4), "R1");
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule